// File: doc/BRIEF.md
# Latency-Hiding Warp Issue Scheduler

This block picks one instruction per clock from a pool of hardware warps. While some warps wait on memory, others keep issuing, so memory latency is hidden. Every warp runs the same short program. Even slots of the program are global loads and odd slots are instructions that consume the value just loaded. A load never holds its warp back. The consumer that follows it is blocked until a fixed memory delay has elapsed. After that delay the warp rejoins the ready set and may issue on that very cycle.

Each cycle the block reports whether an instruction issued, which warp issued it, that warp's program position, and whether the instruction is a load. A warp-enable mask tells the block which warps take part. Cycles where unfinished warps exist but none of them can issue are counted as idle. A completion flag rises once every enabled warp has run its whole program. There is no datapath, no memory model beyond the fixed delay, and no register contents.

Top module: `warp_issue_sched`

## Requirements
- R1: A synchronous active-high reset puts every warp at program position 0, clears all outstanding loads and clears the idle count. In the first cycle after reset, `all_done` is high only if no warp is enabled.
- R2: At most one warp issues per cycle. `issue_valid` high means the warp on `issue_warp` is enabled and has not finished its program.
- R3: The program layout is fixed. An even position is a load, and `issue_load` is 1 when it issues. An odd position is a consumer, and `issue_load` is 0. Each warp runs `PROG_LEN` instructions and then stops.
- R4: Only a consumer can be blocked. A warp whose next instruction is a load is eligible on the cycle after its previous issue.
- R5: If a warp's load issues in cycle t, its consumer does not issue before cycle t+`LOAD_LAT`. The consumer is eligible from that cycle on.
- R6: Among eligible warps, the grant goes to the first one found by searching upward and wrapping, starting just after the warp that issued most recently. After reset the search starts at warp 0.
- R7: `idle_cycles` increases by one for each cycle in which nothing issues while `all_done` is low. In every other cycle it holds its value.
- R8: `all_done` is high exactly when every enabled warp has issued all `PROG_LEN` instructions. While it is high nothing issues. A warp whose enable bit is 0 never issues.
- R9: `issue_pc` equals the number of instructions the issuing warp had issued before this one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| warp_active | input | NUM_WARPS | Enable bit per warp; a warp with 0 takes no part |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_warp | output | $clog2(NUM_WARPS) | Index of the issuing warp |
| issue_pc | output | $clog2(PROG_LEN+1) | Program position of the issued instruction |
| issue_load | output | 1 | 1 when the issued instruction is a load |
| idle_cycles | output | IDLE_W | Count of cycles with unfinished warps but no issue |
| all_done | output | 1 | All enabled warps have finished |

## Verification
Some properties are checked on every cycle:
- only one grant is active;
- the grant always points at an enabled warp;
- a consumer never issues while its own latency counter is still running;
- the idle counter steps by one or holds;
- nothing issues once completion is reported.

Other behaviour can only be shown by the bench's scenarios, which compare each issue against an independent cycle model:
- the exact cycle when a stalled warp comes back;
- the round-robin order, including wrap-around from warp 15 to warp 0;
- the final idle total for one, two, nine and sixteen enabled warps and for an empty mask.

// File: rtl/wsched_pkg.sv
package wsched_pkg;

  // Instruction kind implied by a program position
  typedef enum logic {
    OP_LOAD = 1'b0,
    OP_USE  = 1'b1
  } op_e;

  // Even positions load, odd positions consume the loaded value
  function automatic op_e op_at(input logic pc_lsb);
    return pc_lsb ? OP_USE : OP_LOAD;
  endfunction

  // A warp is blocked only when its next op consumes a value still in flight
  function automatic logic blocked(input op_e op, input logic in_flight);
    return (op == OP_USE) && in_flight;
  endfunction

endpackage

// File: rtl/wsched_slot.sv
module wsched_slot
  import wsched_pkg::*;
#(
  parameter int LOAD_LAT = 8,
  parameter int PROG_LEN = 4,
  localparam int PCW = $clog2(PROG_LEN + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           active,
  input  logic           grant,
  output logic           ready,
  output logic           waiting,
  output logic           done,
  output logic           is_load,
  output logic [PCW-1:0] pc
);

  localparam int CW = (LOAD_LAT > 1) ? $clog2(LOAD_LAT) : 1;

  logic [CW-1:0] lat_cnt;
  logic          in_flight;
  op_e           op;

  assign op        = op_at(pc[0]);
  assign in_flight = (lat_cnt != '0);
  assign waiting   = blocked(op, in_flight);
  assign done      = (pc == PCW'(PROG_LEN));
  assign is_load   = (op == OP_LOAD);
  assign ready     = active && !done && !waiting;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= '0;
      lat_cnt <= '0;
    end else begin
      if (grant) begin
        pc <= pc + PCW'(1);
      end
      if (grant && (op == OP_LOAD)) begin
        lat_cnt <= CW'(LOAD_LAT - 1);
      end else if (in_flight) begin
        lat_cnt <= lat_cnt - CW'(1);
      end
    end
  end

endmodule

// File: rtl/wsched_rr.sv
module wsched_rr #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] sel,
  output logic          any
);

  always_comb begin
    grant = '0;
    sel   = last;
    any   = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (int'(last) + k) % N;
      if (!any && req[idx]) begin
        any        = 1'b1;
        sel        = IW'(idx);
        grant[idx] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import wsched_pkg::*;
#(
  parameter int NUM_WARPS = 16,
  parameter int LOAD_LAT  = 8,
  parameter int PROG_LEN  = 4,
  parameter int IDLE_W    = 16,
  localparam int WARP_W   = $clog2(NUM_WARPS),
  localparam int PC_W     = $clog2(PROG_LEN + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_WARPS-1:0] warp_active,
  output logic                 issue_valid,
  output logic [WARP_W-1:0]    issue_warp,
  output logic [PC_W-1:0]      issue_pc,
  output logic                 issue_load,
  output logic [IDLE_W-1:0]    idle_cycles,
  output logic                 all_done
);

  logic [NUM_WARPS-1:0] ready_vec;
  logic [NUM_WARPS-1:0] wait_vec;
  logic [NUM_WARPS-1:0] done_vec;
  logic [NUM_WARPS-1:0] load_vec;
  logic [NUM_WARPS-1:0] grant;
  logic [PC_W-1:0]      pc_arr [NUM_WARPS];
  logic [WARP_W-1:0]    last_warp;
  logic                 idle_hit;

  for (genvar g = 0; g < NUM_WARPS; g++) begin : g_slot
    wsched_slot #(
      .LOAD_LAT(LOAD_LAT),
      .PROG_LEN(PROG_LEN)
    ) u_slot (
      .clk    (clk),
      .rst    (rst),
      .active (warp_active[g]),
      .grant  (grant[g]),
      .ready  (ready_vec[g]),
      .waiting(wait_vec[g]),
      .done   (done_vec[g]),
      .is_load(load_vec[g]),
      .pc     (pc_arr[g])
    );
  end

  wsched_rr #(.N(NUM_WARPS)) u_rr (
    .req  (ready_vec),
    .last (last_warp),
    .grant(grant),
    .sel  (issue_warp),
    .any  (issue_valid)
  );

  assign issue_pc   = pc_arr[issue_warp];
  assign issue_load = load_vec[issue_warp];
  assign all_done   = &(done_vec | ~warp_active);
  assign idle_hit   = !issue_valid && !all_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_warp   <= WARP_W'(NUM_WARPS - 1);
      idle_cycles <= '0;
    end else begin
      if (issue_valid) begin
        last_warp <= issue_warp;
      end
      if (idle_hit) begin
        idle_cycles <= idle_cycles + IDLE_W'(1);
      end
    end
  end

endmodule

// File: rtl/warp_issue_sched_chk.sv
module warp_issue_sched_chk #(
  parameter int NUM_WARPS = 16,
  parameter int WARP_W    = 4,
  parameter int IDLE_W    = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_WARPS-1:0] warp_active,
  input logic [NUM_WARPS-1:0] grant,
  input logic [NUM_WARPS-1:0] wait_vec,
  input logic                 issue_valid,
  input logic [WARP_W-1:0]    issue_warp,
  input logic                 issue_load,
  input logic [IDLE_W-1:0]    idle_cycles,
  input logic                 all_done
);

  p_single_grant_r2: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> ($countones(grant) == 1));

  p_enabled_only_r8: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> warp_active[issue_warp]);

  p_no_early_use_r5: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && !issue_load) |-> !wait_vec[issue_warp]);

  p_idle_step_r7: assert property (@(posedge clk) disable iff (rst)
    (!issue_valid && !all_done) |=> (idle_cycles == $past(idle_cycles) + IDLE_W'(1)));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (issue_valid || all_done) |=> $stable(idle_cycles));

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    all_done |-> !issue_valid);

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    all_done |=> (all_done || (warp_active != $past(warp_active))));

endmodule

bind warp_issue_sched warp_issue_sched_chk #(
  .NUM_WARPS(NUM_WARPS),
  .WARP_W   (WARP_W),
  .IDLE_W   (IDLE_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .warp_active(warp_active),
  .grant      (grant),
  .wait_vec   (wait_vec),
  .issue_valid(issue_valid),
  .issue_warp (issue_warp),
  .issue_load (issue_load),
  .idle_cycles(idle_cycles),
  .all_done   (all_done)
);

// File: tb/warp_issue_sched_test.sv
module warp_issue_sched_test;

  localparam int NW  = 16;
  localparam int LAT = 8;
  localparam int LEN = 4;
  localparam int IW  = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NW-1:0] warp_active = '0;
  logic          issue_valid;
  logic [3:0]    issue_warp;
  logic [2:0]    issue_pc;
  logic          issue_load;
  logic [IW-1:0] idle_cycles;
  logic          all_done;

  int total = 0;
  int bad   = 0;
  int ticks = 0;

  typedef struct {
    int cyc;
    int w;
    int pc;
    bit ld;
  } exp_t;

  exp_t exp_q[$];
  int   exp_idle;
  int   exp_end;

  always #10 clk = ~clk;

  warp_issue_sched #(
    .NUM_WARPS(NW),
    .LOAD_LAT (LAT),
    .PROG_LEN (LEN),
    .IDLE_W   (IW)
  ) uut (
    .clk        (clk),
    .rst        (rst),
    .warp_active(warp_active),
    .issue_valid(issue_valid),
    .issue_warp (issue_warp),
    .issue_pc   (issue_pc),
    .issue_load (issue_load),
    .idle_cycles(idle_cycles),
    .all_done   (all_done)
  );

  always @(posedge clk) begin
    ticks++;
    if (ticks > 150000) begin
      total++;
      bad++;
      $display("FAIL R8 watchdog: actual=%0d expected=%0d", ticks, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Driver: event model of the issue schedule, pushes expected issues
  task automatic drive(input logic [NW-1:0] mask);
    int pos[NW];
    int earliest[NW];
    int prev = NW - 1;
    int c;
    exp_q.delete();
    exp_idle = 0;
    for (int w = 0; w < NW; w++) begin
      pos[w]      = 0;
      earliest[w] = 0;
    end
    for (c = 0; c < 2000; c++) begin
      bit left = 0;
      bit hit  = 0;
      for (int w = 0; w < NW; w++) if (mask[w] && pos[w] < LEN) left = 1;
      if (!left) break;
      for (int k = 1; k <= NW; k++) begin
        int w = (prev + k) % NW;
        if (!hit && mask[w] && pos[w] < LEN && earliest[w] <= c) begin
          exp_t e;
          hit   = 1;
          e.cyc = c;
          e.w   = w;
          e.pc  = pos[w];
          e.ld  = (pos[w] % 2 == 0);
          exp_q.push_back(e);
          earliest[w] = e.ld ? c + LAT : c + 1;
          pos[w]++;
          prev = w;
        end
      end
      if (!hit) exp_idle++;
    end
    exp_end = c;
  endtask

  // Monitor: resets the design, then compares each cycle with the queue
  task automatic run_case(input logic [NW-1:0] mask);
    int cyc = 0;
    drive(mask);
    warp_active = mask;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(idle_cycles == 0, "R1", "idle count after reset", int'(idle_cycles), 0);
    chk(all_done == (mask == '0), "R1", "done after reset", int'(all_done), int'(mask == '0));
    while (cyc < exp_end) begin
      bit ev = (exp_q.size() > 0) && (exp_q[0].cyc == cyc);
      chk(issue_valid == ev, "R4 R5 R6", "issue slot", int'(issue_valid), int'(ev));
      chk(all_done == 1'b0, "R8", "done too early", int'(all_done), 0);
      if (ev && issue_valid) begin
        exp_t e = exp_q.pop_front();
        chk(issue_warp == e.w, "R6", "warp order", int'(issue_warp), e.w);
        chk(mask[issue_warp] == 1'b1, "R2", "issuer enabled", int'(mask[issue_warp]), 1);
        chk(issue_pc == e.pc, "R9", "program position", int'(issue_pc), e.pc);
        chk(issue_load == e.ld, "R3", "load flag", int'(issue_load), int'(e.ld));
      end else if (ev) begin
        void'(exp_q.pop_front());
      end
      @(negedge clk);
      cyc++;
    end
    chk(all_done == 1'b1, "R8", "done at end", int'(all_done), 1);
    chk(issue_valid == 1'b0, "R8", "quiet at end", int'(issue_valid), 0);
    chk(idle_cycles == exp_idle, "R7", "idle total", int'(idle_cycles), exp_idle);
    chk(exp_q.size() == 0, "R3", "issues left over", exp_q.size(), 0);
    @(negedge clk);
    chk(idle_cycles == exp_idle, "R7", "idle holds after done", int'(idle_cycles), exp_idle);
  endtask

  initial begin
    run_case(16'hFFFF);
    run_case(16'h0020);
    run_case(16'h1008);
    run_case(16'h01FF);
    run_case(16'h8001);
    run_case(16'h0000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule